// File: doc/BRIEF.md
# Configurable I/O Port with Debounced Wake Detection

This block is an eight-bit general-purpose I/O port that software sets up through a small bank of configuration registers. Each bit can be an output or an input. A per-bit inversion mask applies in both directions: it flips the value driven onto an output pin, and it flips the pin value seen on an input. One data register carries the output values on writes. On reads it returns the state of the port.

A subset of the pins, by default pins 0, 1 and 5, can raise a wake event whenever their input changes, on either edge. Each such pin first passes through a two-flop synchroniser. It then passes through a debounce filter that accepts a new level only after the level has held for a parameterised window, about 16 ms at the system clock. Software can bypass the filter for each wake pin separately. A qualified transition produces a one-cycle pulse on the wake output. It also latches a sticky status bit, which software clears by writing a 1 to it. A power sequencer outside the block consumes the wake pulse.

Top module: `gpio_wake_port`

## Requirements
- R1: After reset, every pin is an input (direction register 0xFF, pin_oe 0x00). The inversion, data, wake-control and wake-status registers read 0x00.
- R2: Register addresses are: 0 direction, 1 inversion, 2 data, 3 wake control, 4 wake status. Any other address reads 0x00. A read returns the value selected by the address on the previous clock edge.
- R3: In the direction register, bit value 0 makes the pin an output (pin_oe bit 1) and bit value 1 makes it an input (pin_oe bit 0). The change takes effect the cycle after the write.
- R4: For every pin, pin_out equals the data-register bit XOR the inversion bit. Inversion bit 0 passes the value through and 1 inverts it.
- R5: A data read returns the written bit for output bits. For input bits it returns the pin value after a two-flop synchroniser, XOR the inversion bit.
- R6: With the low nibble as outputs, the high nibble as inputs and no inversion, writing a value to the data register while looping outputs back to inputs gives that nibble in bits [7:4] of a data read.
- R7: Only pins 0, 1 and 5 can raise a wake event. Wake-control bits 0, 1 and 2 enable pins 0, 1 and 5 respectively. A disabled pin and any other pin never set a status bit.
- R8: With filtering active, an input level shorter than the debounce window (CLK_KHZ*DEB_MS cycles) raises no wake event. A level held past the window raises exactly one event.
- R9: Wake-control bits 4, 5 and 6 bypass the debounce for pins 0, 1 and 5. A bypassed pin raises an event on every synchronised transition, so a short pulse gives two events.
- R10: Each qualified transition, rising or falling, gives a one-cycle wake_pulse. It also sets the pin's wake-status bit: bit 0 for pin 0, bit 1 for pin 1, bit 2 for pin 5.
- R11: Writing 1 to a wake-status bit clears it and writing 0 leaves it. A new event in the same cycle keeps the bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Registered read data |
| pin_in | input | 8 | Pin input levels |
| pin_out | output | 8 | Pin output levels after inversion |
| pin_oe | output | 8 | Per-pin output enable |
| wake_pulse | output | 1 | One-cycle pulse per qualified wake transition |

## Verification
The bench builds the port with CLK_KHZ=1 and DEB_MS=16, which gives a 16-cycle debounce window in place of the default of about 400,000 cycles. With that window, a 12-cycle glitch, a level held for 40 cycles and a 3-cycle bypassed pulse all fit in a few hundred cycles. The bench can therefore show rejection, single acceptance and double-edge events on the same pins. The port width and wake-pin mask keep their default values, so the register layout, the loopback nibble and the status bit positions are the ones the requirements state.

// File: rtl/gpio_wake_pkg.sv
package gpio_wake_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR  = 3'd0,
    REG_INV  = 3'd1,
    REG_DATA = 3'd2,
    REG_WCTL = 3'd3,
    REG_WSTS = 3'd4
  } gpio_reg_e;

  // Number of set bits in a mask.
  function automatic int mask_count(input logic [31:0] mask, input int width);
    int n = 0;
    for (int b = 0; b < width; b++) n += int'(mask[b]);
    return n;
  endfunction

  // Position of pin idx among the set bits of mask.
  function automatic int mask_slot(input logic [31:0] mask, input int idx);
    int n = 0;
    for (int b = 0; b < idx; b++) n += int'(mask[b]);
    return n;
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= async_in;
      stage2_q <= stage1_q;
    end
  end

  assign sync_out = stage2_q;
endmodule

// File: rtl/gpio_wake_filter.sv
module gpio_wake_filter #(
  parameter int DEB_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic level_in,
  input  logic bypass,
  input  logic enable,
  output logic event_out
);
  localparam int CW = (DEB_CYCLES < 2) ? 1 : $clog2(DEB_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(DEB_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          filt_q;
  logic          prev_q;
  logic          evt_q;
  logic          eff;

  assign eff = bypass ? level_in : filt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      filt_q <= 1'b0;
      prev_q <= 1'b0;
      evt_q  <= 1'b0;
    end else begin
      if (level_in == filt_q) begin
        cnt_q <= '0;
      end else if (cnt_q == LAST) begin
        filt_q <= level_in;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
      prev_q <= eff;
      evt_q  <= enable && (eff != prev_q);
    end
  end

  assign event_out = evt_q;

  // R8: the filtered level only ever moves to the level the input had
  a_r8_filter_tracks_input: assert property (@(posedge clk) disable iff (rst)
    (filt_q != $past(filt_q)) |-> (filt_q == $past(level_in)));

  // R7: an event is only raised while the pin's wake enable is set
  a_r7_event_needs_enable: assert property (@(posedge clk) disable iff (rst)
    event_out |-> $past(enable));
endmodule

// File: rtl/gpio_wake_port.sv
module gpio_wake_port
  import gpio_wake_pkg::*;
#(
  parameter int          WIDTH     = 8,
  parameter logic [31:0] WAKE_MASK = 32'h0000_0023,
  parameter int          CLK_KHZ   = 25000,
  parameter int          DEB_MS    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [WIDTH-1:0]  cfg_wdata,
  output logic [WIDTH-1:0]  cfg_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  output logic [WIDTH-1:0]  pin_out,
  output logic [WIDTH-1:0]  pin_oe,
  output logic              wake_pulse
);
  localparam int NW         = mask_count(WAKE_MASK, WIDTH);
  localparam int BYP_LSB    = 4;
  localparam int DEB_CYCLES = CLK_KHZ * DEB_MS;

  logic [WIDTH-1:0] dir_q, inv_q, data_q;
  logic [NW-1:0]    wen_q, byp_q, status_q;
  logic [NW-1:0]    wake_evt, clr_mask;
  logic [WIDTH-1:0] sync_pins, level, ctrl_view, read_mux;

  gpio_sync #(.WIDTH(WIDTH)) u_sync (
    .clk(clk), .rst(rst), .async_in(pin_in), .sync_out(sync_pins)
  );

  assign level = sync_pins ^ inv_q;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      if (WAKE_MASK[i]) begin : g_wake
        localparam int K = mask_slot(WAKE_MASK, i);
        gpio_wake_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
          .clk(clk), .rst(rst), .level_in(level[i]),
          .bypass(byp_q[K]), .enable(wen_q[K]), .event_out(wake_evt[K])
        );
      end
    end
  endgenerate

  always_comb begin
    ctrl_view = '0;
    ctrl_view[NW-1:0] = wen_q;
    ctrl_view[BYP_LSB +: NW] = byp_q;
  end

  assign clr_mask = (cfg_we && cfg_addr == REG_WSTS) ? cfg_wdata[NW-1:0] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= '1;
      inv_q    <= '0;
      data_q   <= '0;
      wen_q    <= '0;
      byp_q    <= '0;
      status_q <= '0;
    end else begin
      if (cfg_we) begin
        case (cfg_addr)
          REG_DIR:  dir_q  <= cfg_wdata;
          REG_INV:  inv_q  <= cfg_wdata;
          REG_DATA: data_q <= cfg_wdata;
          REG_WCTL: begin
            wen_q <= cfg_wdata[NW-1:0];
            byp_q <= cfg_wdata[BYP_LSB +: NW];
          end
          default: ;
        endcase
      end
      status_q <= (status_q & ~clr_mask) | wake_evt;
    end
  end

  always_comb begin
    case (cfg_addr)
      REG_DIR:  read_mux = dir_q;
      REG_INV:  read_mux = inv_q;
      REG_DATA: read_mux = (data_q & ~dir_q) | (level & dir_q);
      REG_WCTL: read_mux = ctrl_view;
      REG_WSTS: read_mux = {{(WIDTH-NW){1'b0}}, status_q};
      default:  read_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) cfg_rdata <= '0;
    else     cfg_rdata <= read_mux;
  end

  assign pin_out    = data_q ^ inv_q;
  assign pin_oe     = ~dir_q;
  assign wake_pulse = |wake_evt;

  // R3: a direction write shows on the enables one cycle later, inverted
  a_r3_oe_after_dir_write: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_addr == REG_DIR) |=> (pin_oe == ~$past(cfg_wdata)));

  // R10: a wake pulse always leaves at least one status bit set
  a_r10_pulse_sets_status: assert property (@(posedge clk) disable iff (rst)
    wake_pulse |=> (status_q != '0));

  generate
    for (genvar k = 0; k < NW; k++) begin : g_sts_chk
      // R10: a status bit only rises after its own event
      a_r10_status_from_event: assert property (@(posedge clk) disable iff (rst)
        $rose(status_q[k]) |-> $past(wake_evt[k]));
      // R11: writing 1 clears the bit unless a new event arrives
      a_r11_w1c_clears: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && cfg_addr == REG_WSTS && cfg_wdata[k] && !wake_evt[k]) |=> !status_q[k]);
    end
  endgenerate
endmodule

// File: tb/gpio_wake_port_test.sv
`timescale 1ns/1ps
module gpio_wake_port_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [7:0] pin_in, pin_out, pin_oe, drv = '0;
  logic       loop_en = 1'b0;
  logic       wake_pulse;
  int checks = 0, errors = 0, pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  assign pin_in = loop_en ? {pin_out[3:0], 4'h0} : drv;

  gpio_wake_port #(.CLK_KHZ(1), .DEB_MS(16)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .wake_pulse(wake_pulse)
  );

  always @(negedge clk) if (wake_pulse) pulses++;

  // dir, inv, wdata, pins, exp pin_out, exp pin_oe, exp data read
  localparam logic [55:0] VEC [4] = '{
    {8'hFF, 8'h00, 8'h00, 8'hA5, 8'h00, 8'h00, 8'hA5},
    {8'h00, 8'h00, 8'h3C, 8'hFF, 8'h3C, 8'hFF, 8'h3C},
    {8'h0F, 8'hF0, 8'h5A, 8'h93, 8'hAA, 8'hF0, 8'h53},
    {8'hAA, 8'hFF, 8'h0F, 8'h0F, 8'hF0, 8'h55, 8'hA5}
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); cfg_addr = a;
    @(negedge clk); d = cfg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic settle_clear();
    drv = 8'h00; idle(40); wr(3'd4, 8'hFF); pulses = 0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd(3'd0, v); check("R1", "dir reset", v, 8'hFF);
    check("R1", "oe reset", pin_oe, 8'h00);
    rd(3'd1, v); check("R1", "inv reset", v, 8'h00);
    rd(3'd2, v); check("R1", "data reset", v, 8'h00);
    rd(3'd3, v); check("R1", "wake ctl reset", v, 8'h00);
    rd(3'd4, v); check("R1", "wake status reset", v, 8'h00);
    rd(3'd6, v); check("R2", "unmapped address", v, 8'h00);

    // R3 R4 R5 table walk
    for (int i = 0; i < 4; i++) begin
      drv = VEC[i][31:24];
      wr(3'd0, VEC[i][55:48]);
      wr(3'd1, VEC[i][47:40]);
      wr(3'd2, VEC[i][39:32]);
      idle(4);
      check("R4", "pin_out", pin_out, VEC[i][23:16]);
      check("R3", "pin_oe", pin_oe, VEC[i][15:8]);
      rd(3'd2, v); check("R5", "data read", v, VEC[i][7:0]);
    end

    // R6 loopback nibble
    wr(3'd1, 8'h00); wr(3'd0, 8'hF0); loop_en = 1'b1;
    wr(3'd2, 8'h0A); idle(4);
    rd(3'd2, v); check("R6", "loopback upper nibble", v[7:4], 4'hA);
    wr(3'd2, 8'h05); idle(4);
    rd(3'd2, v); check("R6", "loopback second value", v[7:4], 4'h5);
    loop_en = 1'b0; wr(3'd0, 8'hFF);

    // R7 disabled wake pin
    settle_clear();
    drv = 8'h01; idle(40); drv = 8'h00; idle(40);
    rd(3'd4, v); check("R7", "disabled pin status", v, 8'h00);
    check("R7", "disabled pin pulses", pulses, 0);

    // enable all wake pins, filtering on
    wr(3'd3, 8'h07); rd(3'd3, v); check("R2", "wake ctl readback", v, 8'h07);
    settle_clear();
    // R8 short glitch rejected
    drv = 8'h01; idle(12); drv = 8'h00; idle(40);
    rd(3'd4, v); check("R8", "glitch status", v, 8'h00);
    check("R8", "glitch pulses", pulses, 0);
    // R8 R10 held level accepted once
    drv = 8'h01; idle(8);
    rd(3'd4, v); check("R8", "status before window", v, 8'h00);
    idle(30);
    rd(3'd4, v); check("R10", "status after window", v, 8'h01);
    check("R10", "single pulse", pulses, 1);
    // R11 write-0 keeps, write-1 clears
    wr(3'd4, 8'h00); rd(3'd4, v); check("R11", "write 0 keeps", v, 8'h01);
    wr(3'd4, 8'h01); rd(3'd4, v); check("R11", "write 1 clears", v, 8'h00);

    // R7 non-wake pins
    settle_clear();
    drv = 8'hDC; idle(40); drv = 8'h00; idle(40);
    rd(3'd4, v); check("R7", "non-wake pins status", v, 8'h00);
    check("R7", "non-wake pins pulses", pulses, 0);

    // R10 pin 5 both directions into bit 2
    drv = 8'h20; idle(40);
    rd(3'd4, v); check("R10", "pin5 rise status", v, 8'h04);
    wr(3'd4, 8'h04); pulses = 0;
    drv = 8'h00; idle(40);
    rd(3'd4, v); check("R10", "pin5 fall status", v, 8'h04);
    check("R10", "pin5 fall pulse", pulses, 1);

    // R9 bypass pin 1
    wr(3'd3, 8'h27);
    settle_clear();
    drv = 8'h02; idle(3); drv = 8'h00; idle(10);
    rd(3'd4, v); check("R9", "bypass status", v, 8'h02);
    check("R9", "bypass two pulses", pulses, 2);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule